// File: doc/BRIEF.md
# Deterministic Access Controller for a Random-Operation Memory

This block lets a requester that issues ordinary read and write commands work with a memory that decides on its own, per access, whether to store the offered word or leave the cell alone. The memory always returns the word the cell held before the access. The requester never controls which of the two happens. The controller therefore turns every command into a chain of such blind accesses. It decides from the returned words when the chain may stop, and at that point both the memory contents and the data handed back are correct.

A write repeats an access that carries the target word. It stops as soon as the returned word equals the target. A read first sends one access carrying all zeros and keeps the returned word, which is the true old content. It then always runs the same write loop to put that word back. A retry counter bounds every write loop, and a sticky error flag reports a loop that never converged, for example because the memory's random choice is stuck. Only one command is in flight at a time.

Top module: `rand_mem_ctrl`

## Requirements
- R1: After a synchronous reset, `rsp_done`, `mem_stb` and `err_sticky` are 0 and `rsp_rdata` is all zeros.
- R2: For a write command (`req_write`=1), every memory access carries the request address on `mem_addr` and the command's data on `mem_wdata`. Accesses repeat until a returned word equals that data, and the cell then holds the data.
- R3: A write to a cell that already holds the target word finishes after exactly one access, even when that access is not stored.
- R4: For a read command (`req_write`=0), the first access is issued at the request address with `mem_wdata` all zeros.
- R5: After the first access of a read, the controller always runs the write loop with the captured word at the same address, so a read takes at least two accesses and leaves the cell holding its original content.
- R6: `rsp_rdata` shows the word returned by the first access of the most recent read. Words seen in the restore loop never reach it, and write commands leave it unchanged.
- R7: `mem_stb` is a single-cycle pulse, and no new strobe is issued before `mem_rvalid` has answered the previous one. `rsp_done` is high for exactly one clock per accepted command.
- R8: A command is accepted only when the controller is idle. A `req_valid` pulse during a running sequence has no effect on memory or on completion count.
- R9: If MAX_TRIES write-loop accesses (default 255) pass without a match, the controller ends the sequence with one `rsp_done` and sets `err_sticky`. The flag stays set across later commands until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request, sampled when idle |
| req_write | input | 1 | 1 = write command, 0 = read command |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Data for a write command |
| rsp_rdata | output | DATA_W | Result of the latest read command |
| rsp_done | output | 1 | One-cycle completion pulse |
| err_sticky | output | 1 | Set when a write loop hit the retry limit |
| mem_stb | output | 1 | Memory access strobe, one cycle |
| mem_addr | output | ADDR_W | Memory access address |
| mem_wdata | output | DATA_W | Word offered with the access |
| mem_rdata | input | DATA_W | Word the cell held before the access |
| mem_rvalid | input | 1 | Returned word valid |

## Verification
The hardest state to reach from the ports is the retry limit. A real random source essentially never refuses to store 255 times in a row. The bench's memory model takes a per-command pattern of store/skip decisions, and an all-skip pattern against a cell holding a different word drives the loop to its limit. The same pattern mechanism produces the other rare chains: a probe that gets stored and overwrites the cell with zeros, and restore loops that need several attempts. Adjustable response latency shows that the controller waits for each valid before comparing.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROBE = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_CHECK = 3'd4,
    ST_DONE  = 3'd5
  } rmc_state_e;
endpackage

// File: rtl/rmc_retry_cnt.sv
module rmc_retry_cnt #(
  parameter int MAX_TRIES = 255,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != CNT_W'(MAX_TRIES))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_limit = (cnt_q == CNT_W'(MAX_TRIES));

  // R9: the attempt count never passes the limit
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_TRIES));
endmodule

// File: rtl/rmc_datapath.sv
module rmc_datapath #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              probe_cap,
  input  logic              issue,
  input  logic              ret_cap,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              match
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] tgt_q;    // word the write loop must leave in the cell
  logic [DATA_W-1:0] ret_q;    // scratch: word returned by the latest access
  logic [DATA_W-1:0] rd_q;     // captured probe word
  logic [DATA_W-1:0] wd_q;     // word offered on the bus

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      tgt_q  <= '0;
      ret_q  <= '0;
      rd_q   <= '0;
      wd_q   <= '0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        tgt_q  <= req_write ? req_wdata : '0;
        wd_q   <= '0;   // probe value for reads
      end
      if (probe_cap) begin
        rd_q  <= mem_rdata;
        tgt_q <= mem_rdata;
      end
      if (issue) begin
        wd_q <= tgt_q;
      end
      if (ret_cap) begin
        ret_q <= mem_rdata;
      end
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign rsp_rdata = rd_q;
  assign match     = (ret_q == tgt_q);

  // R6: the read result only moves right after a probe capture
  assert_rdata_src_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rsp_rdata) |-> $past(probe_cap));
endmodule

// File: rtl/rmc_seq_fsm.sv
module rmc_seq_fsm
  import rmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic mem_rvalid,
  input  logic match,
  input  logic at_limit,
  output logic accept,
  output logic probe_cap,
  output logic issue,
  output logic ret_cap,
  output logic mem_stb,
  output logic done,
  output logic err
);
  rmc_state_e state_q;
  logic       stb_q;
  logic       done_q;
  logic       err_q;
  logic       finish;
  logic       give_up;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign probe_cap = (state_q == ST_PROBE) && mem_rvalid;
  assign issue     = (state_q == ST_ISSUE);
  assign ret_cap   = (state_q == ST_WAIT) && mem_rvalid;
  assign finish    = (state_q == ST_CHECK) && (match || at_limit);
  assign give_up   = (state_q == ST_CHECK) && !match && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      stb_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stb_q  <= (accept && !req_write) || issue;
      done_q <= finish;
      if (give_up) err_q <= 1'b1;
      case (state_q)
        ST_IDLE:  if (req_valid) state_q <= req_write ? ST_ISSUE : ST_PROBE;
        ST_PROBE: if (mem_rvalid) state_q <= ST_ISSUE;
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT:  if (mem_rvalid) state_q <= ST_CHECK;
        ST_CHECK: state_q <= finish ? ST_DONE : ST_ISSUE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_stb = stb_q;
  assign done    = done_q;
  assign err     = err_q;

  // R7: strobe and completion are single-cycle pulses
  assert_stb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    mem_stb |=> !mem_stb);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: completion follows a matching compare or the limit
  assert_done_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(match || at_limit));
  // R9: the error flag never clears outside reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/rand_mem_ctrl.sv
module rand_mem_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int MAX_TRIES = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              err_sticky,
  output logic              mem_stb,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid
);
  logic accept, probe_cap, issue, ret_cap, match, at_limit;

  rmc_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .mem_rvalid(mem_rvalid),
    .match     (match),
    .at_limit  (at_limit),
    .accept    (accept),
    .probe_cap (probe_cap),
    .issue     (issue),
    .ret_cap   (ret_cap),
    .mem_stb   (mem_stb),
    .done      (rsp_done),
    .err       (err_sticky)
  );

  rmc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .probe_cap(probe_cap),
    .issue    (issue),
    .ret_cap  (ret_cap),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .rsp_rdata(rsp_rdata),
    .match    (match)
  );

  rmc_retry_cnt #(.MAX_TRIES(MAX_TRIES)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .inc     (issue),
    .at_limit(at_limit)
  );
endmodule

// File: tb/rand_mem_ctrl_tb_top.sv
module rand_mem_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_done, err_sticky, mem_stb;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  rand_mem_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .err_sticky(err_sticky), .mem_stb(mem_stb),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid)
  );

  // Memory model: returns the old word; pattern bit 0 decides store or skip.
  logic [15:0] mem [256];
  logic        pl_req = 1'b0, pl_wr = 1'b0;
  logic [7:0]  pl_a = '0;
  logic [15:0] pl_d = '0;
  logic [31:0] pl_pat = '0;
  logic [1:0]  lat_cfg = '0;
  logic [31:0] pat = '0;
  logic        busy = 1'b0;
  logic [1:0]  dly = '0;
  logic [7:0]  a_q = '0;
  logic [15:0] wd_q = '0;
  int          acc_cnt = 0, ovl_cnt = 0, done_total = 0, cyc = 0;
  logic [15:0] first_wd = '0;
  logic [7:0]  first_a = '0;
  logic        addr_bad = 1'b0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pl_req) begin
      if (pl_wr) mem[pl_a] <= pl_d;
      pat     <= pl_pat;
      acc_cnt <= 0;
      addr_bad <= 1'b0;
    end else if (mem_stb) begin
      if (busy) ovl_cnt <= ovl_cnt + 1;
      if (acc_cnt == 0) begin
        first_wd <= mem_wdata;
        first_a  <= mem_addr;
      end else if (mem_addr != first_a) begin
        addr_bad <= 1'b1;
      end
      busy    <= 1'b1;
      a_q     <= mem_addr;
      wd_q    <= mem_wdata;
      dly     <= lat_cfg;
      acc_cnt <= acc_cnt + 1;
    end else if (busy) begin
      if (dly == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[a_q];
        if (pat[0]) mem[a_q] <= wd_q;
        pat  <= {pat[0], pat[31:1]};
        busy <= 1'b0;
      end else begin
        dly <= dly - 1'b1;
      end
    end
  end

  always @(negedge clk) if (!rst && rsp_done) done_total <= done_total + 1;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic setup(input logic [7:0] a, input logic [15:0] d, input bit wr,
                       input logic [31:0] p, input logic [1:0] l);
    @(negedge clk);
    pl_req = 1'b1; pl_a = a; pl_d = d; pl_wr = wr; pl_pat = p; lat_cfg = l;
    @(negedge clk);
    pl_req = 1'b0;
  endtask

  task automatic run_cmd(input bit wr, input logic [7:0] a, input logic [15:0] d,
                         input bit poke_busy);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a + 8'd1; req_wdata = 16'h9999;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!rsp_done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(1'b0, "R7 done timeout", n, 0);
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] pre;
    logic        do_pre;
    logic [31:0] pat;
    logic [1:0]  lat;
    logic [15:0] exp_mem;
    logic [8:0]  exp_acc;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 8'd3,  16'h1234, 16'h0000, 1'b1, 32'h0000_0001, 2'd0, 16'h1234, 9'd2},
    '{1'b1, 8'd5,  16'hBEEF, 16'h1111, 1'b1, 32'h0000_0004, 2'd2, 16'hBEEF, 9'd4},
    '{1'b1, 8'd7,  16'h5A5A, 16'h5A5A, 1'b1, 32'h0000_0000, 2'd0, 16'h5A5A, 9'd1},
    '{1'b0, 8'd9,  16'h0000, 16'hCAFE, 1'b1, 32'h0000_0000, 2'd1, 16'hCAFE, 9'd2},
    '{1'b0, 8'd10, 16'h0000, 16'h0F0F, 1'b1, 32'h0000_0005, 2'd3, 16'h0F0F, 9'd4},
    '{1'b0, 8'd11, 16'hFFFF, 16'h0000, 1'b1, 32'h0000_0001, 2'd0, 16'h0000, 9'd2},
    '{1'b1, 8'd3,  16'h1234, 16'h0000, 1'b0, 32'hFFFF_FFFF, 2'd0, 16'h1234, 9'd1}
  };

  logic [15:0] last_rd;
  int          d0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rsp_done == 1'b0,   "R1 done after reset", rsp_done, 0);
    chk(mem_stb == 1'b0,    "R1 strobe after reset", mem_stb, 0);
    chk(err_sticky == 1'b0, "R1 error after reset", err_sticky, 0);
    chk(rsp_rdata == 16'h0, "R1 rdata after reset", rsp_rdata, 0);
    last_rd = 16'h0;

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      setup(v.addr, v.pre, v.do_pre, v.pat, v.lat);
      d0 = done_total;
      run_cmd(v.wr, v.addr, v.data, 1'b0);
      if (!v.wr) last_rd = v.exp_mem;
      chk(acc_cnt == int'(v.exp_acc), v.wr ? "R2/R3 access count" : "R5 access count", acc_cnt, v.exp_acc);
      chk(mem[v.addr] == v.exp_mem, v.wr ? "R2 cell content" : "R5 cell restored", mem[v.addr], v.exp_mem);
      chk(rsp_rdata == last_rd, "R6 read result", rsp_rdata, last_rd);
      chk(done_total - d0 == 1, "R7 done count", done_total - d0, 1);
      chk(!addr_bad, "R2 address held", addr_bad, 0);
      if (!v.wr) chk(first_wd == 16'h0, "R4 probe word", first_wd, 0);
      else       chk(first_wd == v.data, "R2 offered word", first_wd, v.data);
      chk(first_a == v.addr, "R4 access address", first_a, v.addr);
    end
    // R3 explicit: one access for a cell already holding the target
    chk(VECS[2].exp_acc == 9'd1, "R3 table sanity", VECS[2].exp_acc, 1);

    // R8: request during a running write is ignored
    setup(8'd21, 16'h4444, 1'b1, 32'h0, 2'd0);
    setup(8'd20, 16'h1111, 1'b1, 32'h0000_0004, 2'd2);
    d0 = done_total;
    run_cmd(1'b1, 8'd20, 16'h7777, 1'b1);
    repeat (10) @(negedge clk);
    chk(done_total - d0 == 1, "R8 single completion", done_total - d0, 1);
    chk(acc_cnt == 4, "R8 access count", acc_cnt, 4);
    chk(mem[20] == 16'h7777, "R8 accepted write", mem[20], 16'h7777);
    setup(8'd21, 16'h0, 1'b0, 32'h0, 2'd0);
    run_cmd(1'b0, 8'd21, 16'h0, 1'b0);
    chk(rsp_rdata == 16'h4444, "R8 ignored write left cell", rsp_rdata, 16'h4444);

    // R9: memory never stores, loop hits the limit
    setup(8'd30, 16'h5555, 1'b1, 32'h0, 2'd0);
    d0 = done_total;
    run_cmd(1'b1, 8'd30, 16'hAAAA, 1'b0);
    chk(acc_cnt == 255, "R9 attempts at limit", acc_cnt, 255);
    chk(err_sticky == 1'b1, "R9 error set", err_sticky, 1);
    chk(done_total - d0 == 1, "R9 done once", done_total - d0, 1);
    chk(mem[30] == 16'h5555, "R9 cell untouched", mem[30], 16'h5555);
    setup(8'd31, 16'h0101, 1'b1, 32'h0, 2'd0);
    run_cmd(1'b1, 8'd31, 16'h0101, 1'b0);
    chk(acc_cnt == 1, "R9 next command runs", acc_cnt, 1);
    chk(err_sticky == 1'b1, "R9 error sticky", err_sticky, 1);
    chk(ovl_cnt == 0, "R7 no overlapping strobes", ovl_cnt, 0);

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(err_sticky == 1'b0, "R1 error cleared by reset", err_sticky, 0);
    chk(rsp_rdata == 16'h0, "R1 rdata cleared by reset", rsp_rdata, 0);
    finish_run();
  end
endmodule